// File: doc/BRIEF.md
# Serial Configuration Loader

This block is the start-up controller that fills a programmable device with its configuration image from an external serial flash. The block is the master of the flash link. It drives the chip select and the serial clock. On its command line it sends a read instruction and then a start address. The configuration stream comes back on a single data input, and the block packs it into bytes. Each completed byte is presented with a one-cycle valid strobe.

The block also takes part in two shared open-drain lines. While a load is not yet confirmed, it pulls the done line low. It pulls the status line low only to report a fault. Configuration does not begin while the external request input is held low. The block expects a fixed number of stream bits. If the done line goes high before that count is reached, or is still low after the count completes, the load is declared faulty. The block then pulses the status line low and starts again from the instruction. After a good load it runs a fixed-length initialization phase and then raises a user-mode flag, which stays set until reset.

Top module: `cfg_loader`

## Requirements
- R1: While reset is held, and in the first cycle after it, chip select is high, the serial clock is low, the done line is pulled low, the status line is not pulled, byte_valid is 0 and user_mode is 0.
- R2: A load does not start while cfg_req_n is low. Chip select stays high for as long as the block is waiting and the request stays low.
- R3: After chip select falls, the command line carries the read byte 0x03 and then the 24-bit start address (parameter START_ADDR), each most significant bit first. The command line changes only on falling serial-clock edges, so it is stable whenever the serial clock is high.
- R4: The serial clock toggles only while chip select is low, and it is low whenever chip select is high.
- R5: The flash launches bit 0 of the stream on the falling edge that follows the 32nd rising edge. The block captures each stream bit on the next falling edge. Bits are packed most significant bit first, the first received bit landing in byte_data[7]. Each byte gets one byte_valid pulse of one cycle, and a complete load yields STREAM_BITS/8 bytes (STREAM_BITS must be a multiple of 8).
- R6: The done line is pulled low from reset until the full bit count has been received, and it is released once chip select goes high at the end of the stream.
- R7: If the done line reads high while the stream is still being loaded, the load is aborted. Chip select goes high, and the status line is pulled low for exactly PULSE_CYC cycles.
- R8: If the done line still reads low SETTLE_CYC cycles after it was released, the status line is pulled low for exactly PULSE_CYC cycles.
- R9: After a fault, chip select stays high for at least PULSE_CYC+1 cycles. The retry then resends the instruction and address, and the byte sequence starts again from the first byte of the stream.
- R10: After a good load, user_mode rises exactly SETTLE_CYC+INIT_CYC cycles after the done line is released. It then stays high with chip select high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req_n | input | 1 | Configuration request; a load may start only while it is high |
| flash_din | input | 1 | Serial data returned by the flash |
| done_in | input | 1 | Sensed level of the open-drain done line |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sclk | output | 1 | Serial clock to the flash |
| flash_cmd | output | 1 | Instruction and address output to the flash |
| done_pull | output | 1 | 1 pulls the done line low |
| status_pull | output | 1 | 1 pulls the status line low |
| byte_data | output | 8 | Most recently completed stream byte |
| byte_valid | output | 1 | One-cycle strobe for each completed byte |
| user_mode | output | 1 | Set when initialization has finished |

## Verification
The assertions rest on a few assumptions about the inputs. The sensed done level is taken to follow the block's own pull, except when an outside agent forces it. The flash is taken to change its data only after a falling serial-clock edge. The stimulus keeps to these assumptions. Its flash model samples the command line on rising edges and launches data half a system cycle after each falling edge. The done line is modelled as the released pull, overridden by explicit force-high or force-low controls. Those controls are applied only during a load or across the release check, and they are withdrawn once the status pulse has begun.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    localparam int OP_W   = 8;
    localparam int ADDR_W = 24;
    localparam int HDR_W  = OP_W + ADDR_W;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_CHECK,
        ST_INIT,
        ST_USER,
        ST_FAULT
    } ld_state_t;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } ld_beat_t;

    function automatic logic [HDR_W-1:0] make_header(
        input logic [OP_W-1:0]   op,
        input logic [ADDR_W-1:0] addr
    );
        return {op, addr};
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cfgld_clkgen.sv
module cfgld_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic abort,
    output logic sclk,
    output logic fall_evt
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap     = run && (cnt == CW'(HALF_DIV - 1));
    assign fall_evt = wrap && sclk && !abort;

    always_ff @(posedge clk) begin
        if (rst || !run || abort) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            sclk <= !sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    // R4: stopping the clock always parks it low
    assert_park_low_R4: assert property (@(posedge clk) disable iff (rst)
        (!run) |=> !sclk);

endmodule

// File: rtl/cfgld_txshift.sv
module cfgld_txshift
    import cfgld_pkg::*;
#(
    parameter logic [OP_W-1:0]   READ_OP    = 8'h03,
    parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic shift,
    output logic bit_out
);
    logic [HDR_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else if (load) begin
            sh <= make_header(READ_OP, START_ADDR);
        end else if (shift) begin
            sh <= {sh[HDR_W-2:0], 1'b0};
        end
    end

    assign bit_out = sh[HDR_W-1];

endmodule

// File: rtl/cfgld_rxpack.sv
module cfgld_rxpack
    import cfgld_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  logic     capture,
    input  logic     din,
    output ld_beat_t beat
);
    localparam int PW = BYTE_W - 1;
    localparam int NW = $clog2(BYTE_W);

    logic [PW-1:0] partial;
    logic [NW-1:0] nbits;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            partial <= '0;
            nbits   <= '0;
            beat    <= '0;
        end else begin
            beat.valid <= 1'b0;
            if (capture) begin
                if (nbits == NW'(BYTE_W - 1)) begin
                    beat.valid <= 1'b1;
                    beat.data  <= {partial, din};
                    nbits      <= '0;
                end else begin
                    partial <= {partial[PW-2:0], din};
                    nbits   <= nbits + 1'b1;
                end
            end
        end
    end

    // R5: a byte strobe never lasts more than one cycle
    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        beat.valid |=> !beat.valid);

endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
    import cfgld_pkg::*;
#(
    parameter int STREAM_BITS = 64,
    parameter int SETTLE_CYC  = 4,
    parameter int INIT_CYC    = 16,
    parameter int PULSE_CYC   = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_req_n,
    input  logic done_in,
    input  logic fall_evt,
    output logic cs_n,
    output logic run,
    output logic abort,
    output logic load,
    output logic shift,
    output logic capture,
    output logic done_pull,
    output logic status_pull,
    output logic user_mode
);
    localparam int MAXC = max2(max2(STREAM_BITS, HDR_W), max2(max2(SETTLE_CYC, INIT_CYC), PULSE_CYC));
    localparam int CW   = $clog2(MAXC + 1);

    ld_state_t     st;
    logic [CW-1:0] cnt;
    logic          loading;

    assign loading     = (st == ST_CMD) || (st == ST_DATA);
    assign abort       = loading && done_in;
    assign cs_n        = !loading;
    assign run         = loading;
    assign load        = (st == ST_IDLE) && cfg_req_n;
    assign shift       = (st == ST_CMD) && fall_evt;
    assign capture     = (st == ST_DATA) && fall_evt;
    assign done_pull   = loading || (st == ST_IDLE) || (st == ST_FAULT);
    assign status_pull = (st == ST_FAULT);
    assign user_mode   = (st == ST_USER);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (cfg_req_n) st <= ST_CMD;
                end
                ST_CMD: begin
                    if (done_in) begin
                        st  <= ST_FAULT;
                        cnt <= '0;
                    end else if (fall_evt) begin
                        if (cnt == CW'(HDR_W - 1)) begin
                            st  <= ST_DATA;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (done_in) begin
                        st  <= ST_FAULT;
                        cnt <= '0;
                    end else if (fall_evt) begin
                        if (cnt == CW'(STREAM_BITS - 1)) begin
                            st  <= ST_CHECK;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_CHECK: begin
                    if (cnt == CW'(SETTLE_CYC - 1)) begin
                        st  <= done_in ? ST_INIT : ST_FAULT;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_INIT: begin
                    if (cnt == CW'(INIT_CYC - 1)) begin
                        st  <= ST_USER;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_USER: begin
                    st <= ST_USER;
                end
                ST_FAULT: begin
                    if (cnt == CW'(PULSE_CYC - 1)) begin
                        st  <= ST_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R2: a low request keeps the sequencer waiting
    assert_no_start_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !cfg_req_n) |=> (st == ST_IDLE));

    // R10: user mode is final
    assert_user_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_USER) |=> (st == ST_USER));

    // R7: a high done level during a load always leads to the fault state
    assert_early_fault_R7: assert property (@(posedge clk) disable iff (rst)
        (loading && done_in) |=> (st == ST_FAULT));

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfgld_pkg::*;
#(
    parameter int                HALF_DIV    = 2,
    parameter int                STREAM_BITS = 64,
    parameter int                SETTLE_CYC  = 4,
    parameter int                INIT_CYC    = 16,
    parameter int                PULSE_CYC   = 8,
    parameter logic [OP_W-1:0]   READ_OP     = 8'h03,
    parameter logic [ADDR_W-1:0] START_ADDR  = 24'h000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_req_n,
    input  logic              flash_din,
    input  logic              done_in,
    output logic              flash_cs_n,
    output logic              flash_sclk,
    output logic              flash_cmd,
    output logic              done_pull,
    output logic              status_pull,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid,
    output logic              user_mode
);
    logic     run;
    logic     abort;
    logic     fall_evt;
    logic     load;
    logic     shift;
    logic     capture;
    ld_beat_t beat;

    cfgld_seq #(
        .STREAM_BITS (STREAM_BITS),
        .SETTLE_CYC  (SETTLE_CYC),
        .INIT_CYC    (INIT_CYC),
        .PULSE_CYC   (PULSE_CYC)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .cfg_req_n   (cfg_req_n),
        .done_in     (done_in),
        .fall_evt    (fall_evt),
        .cs_n        (flash_cs_n),
        .run         (run),
        .abort       (abort),
        .load        (load),
        .shift       (shift),
        .capture     (capture),
        .done_pull   (done_pull),
        .status_pull (status_pull),
        .user_mode   (user_mode)
    );

    cfgld_clkgen #(
        .HALF_DIV (HALF_DIV)
    ) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .abort    (abort),
        .sclk     (flash_sclk),
        .fall_evt (fall_evt)
    );

    cfgld_txshift #(
        .READ_OP    (READ_OP),
        .START_ADDR (START_ADDR)
    ) u_tx (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .shift   (shift),
        .bit_out (flash_cmd)
    );

    cfgld_rxpack u_rx (
        .clk     (clk),
        .rst     (rst),
        .clear   (load),
        .capture (capture),
        .din     (flash_din),
        .beat    (beat)
    );

    assign byte_data  = beat.data;
    assign byte_valid = beat.valid;

    // R4: no clock activity with the flash deselected
    assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (rst)
        flash_cs_n |-> !flash_sclk);

    // R3: command output holds while the serial clock is high
    assert_cmd_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (!flash_cs_n && flash_sclk) |-> $stable(flash_cmd));

    // R7: status is reported only with the flash deselected
    assert_status_cs_R7: assert property (@(posedge clk) disable iff (rst)
        status_pull |-> flash_cs_n);

    // R6: the done line is released only outside a load
    assert_release_R6: assert property (@(posedge clk) disable iff (rst)
        (!done_pull) |-> flash_cs_n);

    // R10: user mode implies the done line is released
    assert_user_done_R10: assert property (@(posedge clk) disable iff (rst)
        user_mode |-> (!done_pull && flash_cs_n));

endmodule

// File: tb/cfg_loader_bench.sv
`timescale 1ns/1ps
module cfg_loader_bench;

    localparam int          HALF   = 2;
    localparam int          BITS   = 64;
    localparam int          SETTLE = 4;
    localparam int          INITC  = 16;
    localparam int          PULSE  = 8;
    localparam logic [23:0] ADDR   = 24'h00C35A;
    localparam int          NBYTES = BITS / 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_req_n = 1'b0;
    logic       flash_din = 1'b0;
    logic       force_hi = 1'b0;
    logic       force_lo = 1'b0;
    logic       done_in;
    logic       flash_cs_n, flash_sclk, flash_cmd;
    logic       done_pull, status_pull, byte_valid, user_mode;
    logic [7:0] byte_data;

    int checks = 0;
    int fails = 0;
    int attempts = 0;
    int exp_idx = 0;
    int rises = 0;
    int dbit = 0;
    int cs_high_run = 0;
    int stat_run = 0;
    int rel_cnt = 0;
    int gate_viol = 0;
    bit gate_watch = 1'b0;
    bit mon_en = 1'b0;
    bit prev_cs = 1'b1;
    bit prev_sclk = 1'b0;
    bit prev_stat = 1'b0;
    bit prev_user = 1'b0;
    logic [31:0] hdr = '0;
    string fault_tag = "R7";

    assign done_in = force_hi ? 1'b1 : (force_lo ? 1'b0 : !done_pull);

    cfg_loader #(
        .HALF_DIV    (HALF),
        .STREAM_BITS (BITS),
        .SETTLE_CYC  (SETTLE),
        .INIT_CYC    (INITC),
        .PULSE_CYC   (PULSE),
        .READ_OP     (8'h03),
        .START_ADDR  (ADDR)
    ) u_cfg_loader (
        .clk         (clk),
        .rst         (rst),
        .cfg_req_n   (cfg_req_n),
        .flash_din   (flash_din),
        .done_in     (done_in),
        .flash_cs_n  (flash_cs_n),
        .flash_sclk  (flash_sclk),
        .flash_cmd   (flash_cmd),
        .done_pull   (done_pull),
        .status_pull (status_pull),
        .byte_data   (byte_data),
        .byte_valid  (byte_valid),
        .user_mode   (user_mode)
    );

    initial forever #2.5 clk = ~clk;

    function automatic logic [7:0] mem_byte(input int k);
        return 8'((k * 59 + 165) ^ (k << 3));
    endfunction

    function automatic logic stream_bit(input int j);
        logic [7:0] b;
        b = mem_byte(j / 8);
        return b[7 - (j % 8)];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // flash model and per-clock reference comparison
    initial forever begin
        @(negedge clk);
        if (mon_en) begin
            if (gate_watch && !flash_cs_n) gate_viol++;
            if (flash_cs_n && flash_sclk)
                check(1'b0, "R4", "sclk high while deselected", 32'(flash_sclk), 32'd0);
            if (!flash_cs_n && !done_pull)
                check(1'b0, "R6", "done released during load", 32'(done_pull), 32'd1);
            if (prev_cs && !flash_cs_n) begin
                attempts++;
                if (attempts > 1)
                    check(cs_high_run >= PULSE + 1, "R9", "deselect gap before retry",
                          32'(cs_high_run), 32'(PULSE + 1));
                rises = 0; dbit = 0; exp_idx = 0; hdr = '0;
            end
            if (flash_cs_n) cs_high_run++; else cs_high_run = 0;
            if (!flash_cs_n && flash_sclk && !prev_sclk) begin
                rises++;
                if (rises <= 32) hdr = {hdr[30:0], flash_cmd};
                if (rises == 32)
                    check(hdr == {8'h03, ADDR}, "R3", "instruction and address", hdr, {8'h03, ADDR});
            end
            if (!flash_cs_n && !flash_sclk && prev_sclk && rises >= 32) begin
                flash_din = stream_bit(dbit);
                dbit++;
            end
            if (byte_valid) begin
                check(byte_data == mem_byte(exp_idx),
                      (attempts > 1 && exp_idx == 0) ? "R9" : "R5",
                      "stream byte", 32'(byte_data), 32'(mem_byte(exp_idx)));
                exp_idx++;
            end
            if (status_pull) stat_run++;
            if (prev_stat && !status_pull) begin
                check(stat_run == PULSE, fault_tag, "status pulse width", 32'(stat_run), 32'(PULSE));
                stat_run = 0;
            end
            if (!done_pull && !user_mode) rel_cnt++;
            if (user_mode && !prev_user)
                check(rel_cnt == SETTLE + INITC, "R10", "release to user mode cycles",
                      32'(rel_cnt), 32'(SETTLE + INITC));
            prev_cs = flash_cs_n; prev_sclk = flash_sclk;
            prev_stat = status_pull; prev_user = user_mode;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "WD", "watchdog expired", 32'd0, 32'd1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(flash_cs_n == 1'b1, "R1", "cs_n in reset", 32'(flash_cs_n), 32'd1);
        check(flash_sclk == 1'b0, "R1", "sclk in reset", 32'(flash_sclk), 32'd0);
        check(done_pull == 1'b1, "R1", "done pull in reset", 32'(done_pull), 32'd1);
        check(status_pull == 1'b0, "R1", "status in reset", 32'(status_pull), 32'd0);
        check(byte_valid == 1'b0 && user_mode == 1'b0, "R1", "valid/user in reset",
              32'({byte_valid, user_mode}), 32'd0);
        rst = 1'b0;
        mon_en = 1'b1;
        @(negedge clk);
        check(flash_cs_n == 1'b1 && done_pull == 1'b1, "R1", "state after reset",
              32'({flash_cs_n, done_pull}), 32'd3);

        // R2: request held low
        gate_watch = 1'b1;
        repeat (40) @(negedge clk);
        gate_watch = 1'b0;
        check(gate_viol == 0, "R2", "selected while request low", 32'(gate_viol), 32'd0);

        // R8: done line held low by an outside agent
        fault_tag = "R8";
        force_lo = 1'b1;
        cfg_req_n = 1'b1;
        while (!status_pull) @(negedge clk);
        check(exp_idx == NBYTES, "R5", "bytes in full load", 32'(exp_idx), 32'(NBYTES));
        check(flash_cs_n == 1'b1, "R8", "deselected on missing done", 32'(flash_cs_n), 32'd1);
        force_lo = 1'b0;
        cfg_req_n = 1'b0;
        while (status_pull) @(negedge clk);
        gate_watch = 1'b1; gate_viol = 0;
        repeat (20) @(negedge clk);
        gate_watch = 1'b0;
        check(gate_viol == 0, "R2", "no retry while request low", 32'(gate_viol), 32'd0);
        check(attempts == 1, "R2", "attempt count before retry", 32'(attempts), 32'd1);

        // R7: done line rises early
        fault_tag = "R7";
        cfg_req_n = 1'b1;
        while (exp_idx < 2) @(negedge clk);
        force_hi = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(status_pull == 1'b1 && flash_cs_n == 1'b1, "R7", "abort on early done",
              32'({status_pull, flash_cs_n}), 32'd3);
        check(exp_idx < NBYTES, "R7", "load cut short", 32'(exp_idx), 32'(NBYTES - 1));
        force_hi = 1'b0;
        while (status_pull) @(negedge clk);

        // good load after the retry
        rel_cnt = 0;
        while (!user_mode) @(negedge clk);
        check(attempts == 3, "R9", "retries after faults", 32'(attempts), 32'd3);
        check(exp_idx == NBYTES, "R5", "bytes in good load", 32'(exp_idx), 32'(NBYTES));
        check(done_pull == 1'b0, "R6", "done released after load", 32'(done_pull), 32'd0);
        repeat (30) @(negedge clk);
        check(user_mode == 1'b1 && flash_cs_n == 1'b1 && status_pull == 1'b0, "R10",
              "user mode holds", 32'({user_mode, flash_cs_n, status_pull}), 32'd6);
        summary();
        $finish;
    end

endmodule